// File: doc/BRIEF.md
# Programmable Transmit Inter-Frame Gap Controller

This block sits beside a byte-wide Ethernet transmitter and enforces the quiet period between consecutive frames. A frame source asks to begin a frame by raising a request. The block grants the request while its ready output is high and then keeps ready low while the frame is in progress. When the transmitter signals the final byte, the block counts idle byte clocks and raises ready again only after the required gap has elapsed. One byte clock carries 8 bit times, so one idle cycle is one byte clock.

The gap length comes from two software-visible registers reached through a small read/write port. The first is an 8-bit gap value. The second is a configuration word holding one adjust-enable bit. The enable bit must be set for the programmed value to matter. If it is clear, or if the programmed value is below 12, the gap is exactly 12 idle cycles (96 bit times). Otherwise the gap equals the programmed value, at most 255 cycles. The effective gap is captured when the final byte is accepted, so reprogramming the registers never disturbs a gap that has already started.

Top module: `tx_ifg_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the gap value is 0, the enable bit is 0, and frm_ready is 1. Reads of both registers return 0.
- R2: The gap register is at address 0x08. Bits 7:0 are read/write. Bits 31:8 always read 0, and writes to them are ignored.
- R3: The configuration register is at address 0x04. Only bit 25, the adjust enable, is stored. All other bits read 0.
- R4: Read data appears on reg_rdata in the cycle after reg_rd is sampled high and is held until the next read. An address that maps to no register reads 0.
- R5: A request seen while frm_ready is high is accepted at that edge, and frm_ready is low in the next cycle. A request seen while frm_ready is low is not accepted and is not lost. A source that keeps requesting is granted once the gap ends.
- R6: With the enable bit clear, the gap is 12 idle cycles, whatever the gap value.
- R7: With the enable bit set and a gap value below 12, the gap is 12 idle cycles.
- R8: With the enable bit set and a gap value of 12 to 255, the gap equals the gap value. The gap is the number of cycles during which frm_ready is low, counted from the cycle after the final byte up to the last cycle before frm_ready returns high.
- R9: The gap length is captured when the final byte is accepted. A register write made during a gap does not change that gap and takes effect from the next frame end.
- R10: byte_valid with byte_last is treated as a frame end only while a granted frame is in progress. Outside a frame it has no effect, and frm_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| frm_req | input | 1 | Source asks to start a frame |
| frm_ready | output | 1 | High when a new frame may start |
| byte_valid | input | 1 | Transmitter moves a byte this cycle |
| byte_last | input | 1 | The byte moved is the final byte of the frame |

## Verification
The checker watches three things on every cycle:
- frm_ready stays low throughout a granted frame and drops right after a grant.
- frm_ready never comes back before at least 12 idle cycles have passed since the frame end, counted by the checker's own tracker.
- Reserved and unmapped read bits are always zero.

The exact gap length for each enable and value combination cannot be shown by a property, so the bench sweeps every gap value with the enable both clear and set. The bench alone also shows that a write made mid-gap is deferred and that a held-off request is granted later. It also checks that a stray final-byte pulse outside a frame leaves frm_ready high.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  localparam int IFG_ADDR_W = 8;
  localparam int IFG_DATA_W = 32;
  localparam int IFG_GAP_W  = 8;
  localparam int IFG_MIN    = 12;
  localparam int IFG_EN_BIT = 25;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } ifg_state_e;
endpackage

// File: rtl/ifg_regs.sv
module ifg_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int GAP_W  = 8,
  parameter int EN_BIT = 25,
  parameter logic [ADDR_W-1:0] GAP_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [GAP_W-1:0]  gap_val,
  output logic              adj_en
);
  logic [DATA_W-1:0] rd_mux;
  logic              hit_gap;
  logic              hit_cfg;

  assign hit_gap = (addr == GAP_ADDR);
  assign hit_cfg = (addr == CFG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_val <= '0;
      adj_en  <= 1'b0;
    end else if (wr) begin
      if (hit_gap) gap_val <= wdata[GAP_W-1:0];
      if (hit_cfg) adj_en  <= wdata[EN_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_gap)      rd_mux[GAP_W-1:0] = gap_val;
    else if (hit_cfg) rd_mux[EN_BIT]    = adj_en;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/ifg_gap_calc.sv
module ifg_gap_calc #(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 12
) (
  input  logic [GAP_W-1:0] gap_val,
  input  logic             adj_en,
  output logic [GAP_W-1:0] eff_gap
);
  localparam logic [GAP_W-1:0] FLOOR = GAP_W'(MIN_GAP);

  always_comb begin
    if (adj_en && (gap_val >= FLOOR)) eff_gap = gap_val;
    else                              eff_gap = FLOOR;
  end
endmodule

// File: rtl/ifg_gap_timer.sv
module ifg_gap_timer
  import ifg_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_req,
  input  logic             byte_valid,
  input  logic             byte_last,
  input  logic [GAP_W-1:0] eff_gap,
  output logic             frm_ready
);
  localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

  ifg_state_e       state;
  logic [GAP_W-1:0] cnt;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      gap_q     <= '0;
      frm_ready <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (frm_req) begin
            state     <= ST_FRAME;
            frm_ready <= 1'b0;
          end
        end
        ST_FRAME: begin
          if (byte_valid && byte_last) begin
            state <= ST_GAP;
            cnt   <= ONE;
            gap_q <= eff_gap;
          end
        end
        ST_GAP: begin
          if (cnt == gap_q) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            frm_ready <= 1'b1;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: begin
          state     <= ST_IDLE;
          frm_ready <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/tx_ifg_ctrl.sv
module tx_ifg_ctrl
  import ifg_pkg::*;
#(
  parameter int ADDR_W  = IFG_ADDR_W,
  parameter int DATA_W  = IFG_DATA_W,
  parameter int GAP_W   = IFG_GAP_W,
  parameter int MIN_GAP = IFG_MIN,
  parameter int EN_BIT  = IFG_EN_BIT,
  parameter logic [ADDR_W-1:0] GAP_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frm_req,
  output logic              frm_ready,
  input  logic              byte_valid,
  input  logic              byte_last
);
  logic [GAP_W-1:0] gap_val;
  logic [GAP_W-1:0] eff_gap;
  logic             adj_en;

  ifg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_W(GAP_W), .EN_BIT(EN_BIT),
    .GAP_ADDR(GAP_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .gap_val(gap_val), .adj_en(adj_en)
  );

  ifg_gap_calc #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_calc (
    .gap_val(gap_val), .adj_en(adj_en), .eff_gap(eff_gap)
  );

  ifg_gap_timer #(.GAP_W(GAP_W)) u_timer (
    .clk(clk), .rst(rst), .frm_req(frm_req), .byte_valid(byte_valid),
    .byte_last(byte_last), .eff_gap(eff_gap), .frm_ready(frm_ready)
  );
endmodule

// File: rtl/tx_ifg_ctrl_chk.sv
module tx_ifg_ctrl_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 12,
  parameter int EN_BIT  = 25,
  parameter logic [ADDR_W-1:0] GAP_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h04
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              frm_req,
  input logic              frm_ready,
  input logic              byte_valid,
  input logic              byte_last
);
  localparam int CW = GAP_W + 1;
  localparam logic [DATA_W-1:0] CFG_MASK = ~(DATA_W'(1) << EN_BIT);

  logic          in_frame = 1'b0;
  logic [CW-1:0] idle_cnt = '0;
  logic          rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst) begin
      in_frame <= 1'b0;
      idle_cnt <= '0;
    end else if (in_frame && byte_valid && byte_last) begin
      in_frame <= 1'b0;
      idle_cnt <= '0;
    end else if (frm_req && frm_ready) begin
      in_frame <= 1'b1;
    end else if (!frm_ready && !in_frame && (idle_cnt != {CW{1'b1}})) begin
      idle_cnt <= idle_cnt + CW'(1);
    end
  end

  // R1: ready comes out of reset high
  always @(posedge clk) begin
    if (rst_seen && !rst) assert (frm_ready) else $error("p_reset_ready_r1");
  end

  p_grant_drops_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (frm_req && frm_ready) |=> !frm_ready);

  p_frame_holds_low_r5: assert property (@(posedge clk) disable iff (rst)
    in_frame |-> !frm_ready);

  p_min_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(frm_ready) |-> (idle_cnt >= CW'(MIN_GAP)));

  p_gap_reserved_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == GAP_ADDR) |=> (reg_rdata[DATA_W-1:GAP_W] == '0));

  p_cfg_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == CFG_ADDR) |=> ((reg_rdata & CFG_MASK) == '0));

  p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr != GAP_ADDR && reg_addr != CFG_ADDR) |=> (reg_rdata == '0));
endmodule

bind tx_ifg_ctrl tx_ifg_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_W(GAP_W), .MIN_GAP(MIN_GAP),
  .EN_BIT(EN_BIT), .GAP_ADDR(GAP_ADDR), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .frm_req(frm_req), .frm_ready(frm_ready),
  .byte_valid(byte_valid), .byte_last(byte_last)
);

// File: tb/test_tx_ifg_ctrl.sv
module test_tx_ifg_ctrl;
  localparam logic [7:0] A_GAP = 8'h08;
  localparam logic [7:0] A_CFG = 8'h04;
  localparam logic [7:0] A_BAD = 8'h10;
  localparam logic [31:0] EN_WORD = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frm_req = 1'b0;
  logic        frm_ready;
  logic        byte_valid = 1'b0;
  logic        byte_last = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tx_ifg_ctrl i_tx_ifg_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frm_req(frm_req), .frm_ready(frm_ready),
    .byte_valid(byte_valid), .byte_last(byte_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // Grant a frame, send len bytes; leaves the bench at the first idle cycle.
  task automatic send_frame(input int len, input string req);
    @(negedge clk);
    check({req, " ready before grant"}, 32'(frm_ready), 32'd1);
    frm_req = 1'b1;
    @(negedge clk);
    frm_req = 1'b0;
    check("R5 ready low after grant", 32'(frm_ready), 32'd0);
    for (int i = 0; i < len; i++) begin
      byte_valid = 1'b1;
      byte_last  = (i == len - 1);
      @(negedge clk);
    end
    byte_valid = 1'b0;
    byte_last  = 1'b0;
  endtask

  task automatic count_gap(output int cyc);
    cyc = 0;
    while (!frm_ready && cyc < 400) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int g;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 ready after reset", 32'(frm_ready), 32'd1);
    rd_reg(A_GAP, d); check("R1 gap reset", d, 32'h0);
    rd_reg(A_CFG, d); check("R1 cfg reset", d, 32'h0);

    // R2: gap register bits
    wr_reg(A_GAP, 32'hFFFF_FFFF); rd_reg(A_GAP, d); check("R2 gap all ones", d, 32'h0000_00FF);
    wr_reg(A_GAP, 32'h1234_5A3C); rd_reg(A_GAP, d); check("R2 gap pattern", d, 32'h0000_003C);

    // R3: config register keeps only the enable bit
    wr_reg(A_CFG, 32'hFFFF_FFFF); rd_reg(A_CFG, d); check("R3 cfg all ones", d, EN_WORD);
    wr_reg(A_CFG, ~EN_WORD);      rd_reg(A_CFG, d); check("R3 cfg others", d, 32'h0);

    // R4: unmapped read, and data held between reads
    rd_reg(A_BAD, d); check("R4 unmapped", d, 32'h0);
    wr_reg(A_GAP, 32'h55); rd_reg(A_GAP, d);
    @(negedge clk); @(negedge clk);
    check("R4 rdata held", reg_rdata, 32'h55);

    // R10: stray final byte outside a frame
    @(negedge clk);
    byte_valid = 1'b1; byte_last = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0; byte_last = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R10 ready stays high", 32'(frm_ready), 32'd1);
      @(negedge clk);
    end

    // R6/R7/R8: full sweep of gap value with enable clear and set
    for (int en = 0; en < 2; en++) begin
      wr_reg(A_CFG, (en != 0) ? EN_WORD : 32'h0);
      for (int v = 0; v < 256; v++) begin
        int exp;
        string tag;
        exp = (en != 0 && v >= 12) ? v : 12;
        tag = (en == 0) ? "R6" : ((v < 12) ? "R7" : "R8");
        wr_reg(A_GAP, 32'(v));
        send_frame(1 + (v % 4), tag);
        count_gap(g);
        check({tag, " gap length"}, 32'(g), 32'(exp));
      end
    end

    // R9: write during a gap is deferred
    wr_reg(A_CFG, EN_WORD);
    wr_reg(A_GAP, 32'd20);
    send_frame(3, "R9");
    g = 0;
    while (!frm_ready && g < 400) begin
      g++;
      if (g == 3) begin
        reg_wr = 1'b1; reg_addr = A_GAP; reg_wdata = 32'd40;
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
    end
    reg_wr = 1'b0;
    check("R9 current gap unchanged", 32'(g), 32'd20);
    send_frame(2, "R9");
    count_gap(g);
    check("R9 next gap uses new value", 32'(g), 32'd40);

    // R5: request held during gap is granted afterwards
    wr_reg(A_GAP, 32'd15);
    send_frame(2, "R5");
    frm_req = 1'b1;
    count_gap(g);
    check("R5 held-off gap length", 32'(g), 32'd15);
    check("R5 ready at gap end", 32'(frm_ready), 32'd1);
    @(negedge clk);
    frm_req = 1'b0;
    check("R5 held request granted", 32'(frm_ready), 32'd0);
    byte_valid = 1'b1; byte_last = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0; byte_last = 1'b0;
    count_gap(g);
    check("R5 gap after late grant", 32'(g), 32'd15);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule